// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Demodulator

This block recovers a reply of known length from a tag. The reply arrives on a one-bit line that an external comparator has already thresholded. A 1-bit is sent as a burst of subcarrier cycles, so the line toggles many times within that bit. A 0-bit leaves the line quiet. The reply carries no start marker and no length field, so the receiver must be told how many bits to expect. It is also timed against the end of the outgoing frame.

A `start_i` pulse marks the moment the transmitter finished its frame and restarted the shared timer. The block then moves an external keystream generator forward by two positions. If decryption is on, it also reads one keystream bit per expected data bit into a mask. All of this happens before the reply is due. At a fixed wait after `start_i`, the block splits time into equal bit intervals and counts the level changes of the synchronised line in each interval. It decides each bit from a window on that count and toggles the matching mask bit when the bit is 1.

After the last bit, the block presents the word, the bit count and a one-cycle valid pulse. In the same cycle it pulses a timer-restart output, so that the next exchange stays aligned.

Top module: `sce_demod`

## Requirements
- R1: The bit count used for a frame is the requested `nbits_i`, capped at MAX_BITS (32). `nbits_o` reports that capped value when the frame completes.
- R2: Cycles are numbered from 0, where cycle 0 is the first cycle after the clock edge that samples `start_i`. Bit interval i covers cycles WAIT_TICKS + i*BIT_TICKS through WAIT_TICKS + (i+1)*BIT_TICKS - 1. `line_i` passes through a two-stage synchroniser and then one previous-level register, which is reset to 0. A change of `line_i` sampled at the edge that ends cycle T is counted in cycle T+2. Each cycle adds at most one edge.
- R3: A bit is decoded as 1 exactly when its interval's edge count is at least 21 and at most 59. Otherwise it is decoded as 0.
- R4: The edge counter is EDGE_W (6) bits wide. It saturates at 63 instead of wrapping, so 64 to 98 edges in one interval decode as 0.
- R5: Bit i of the reply appears at `data_o[i]` (the first bit received is the least significant). Bits at and above the frame's bit count are 0.
- R6: After `start_i`, `ks_adv_o` pulses exactly 2 times. When `decrypt_i` was high at start, it then pulses once per data bit, and `ks_bit_i` is captured as mask bit i in the cycle of the i-th of those pulses. The result is the mask XOR the decoded bits. With decryption off, the mask is 0.
- R7: `valid_o` and `timer_clr_o` are high together for exactly one cycle, at cycle WAIT_TICKS + n*BIT_TICKS. At that point `data_o` and `nbits_o` take their new values, and they hold them until the next completion.
- R8: A `start_i` pulse that arrives while a frame is in progress is ignored. It has no effect on timing, result or keystream advances.
- R9: With a bit count of 0, the frame completes at cycle WAIT_TICKS with `data_o` = 0, and no mask bits are collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse: transmitter finished and restarted the shared timer |
| line_i | input | 1 | Thresholded receive line (asynchronous) |
| nbits_i | input | 7 | Requested number of reply bits, sampled at start |
| decrypt_i | input | 1 | Remove keystream from the reply, sampled at start |
| ks_bit_i | input | 1 | Current keystream bit |
| ks_adv_o | output | 1 | Advance keystream generator by one position |
| data_o | output | 32 | Received word, first bit in bit 0 |
| nbits_o | output | 6 | Number of bits in `data_o` |
| valid_o | output | 1 | One-cycle pulse: new result |
| timer_clr_o | output | 1 | One-cycle pulse: restart the shared timer |

## Verification
The assertions check on every cycle that the edge counter steps by at most one and stays pinned once it saturates, and that the interval phase stays inside one bit time. On every completion they also check that the valid pulse lasts one cycle, that the reported count never exceeds 32, that bits above the count are clear, and that the number of keystream advances matches the frame's count and decrypt setting. Only the bench scenarios can show that the window bounds are exactly 21 and 59, that saturation turns large counts into 0, and that the capture interval sits at the right cycles relative to start. The bench sweeps every edge count from 0 to 98, so the saturation and window bounds are both covered. The bench scenarios also show that the mask bits line up with the keystream positions, that the count is capped, and that a mid-frame start changes nothing.

// File: rtl/sce_pkg.sv
package sce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADV  = 3'd1,
    ST_COLL = 3'd2,
    ST_WAIT = 3'd3,
    ST_RX   = 3'd4
  } sce_state_t;
endpackage

// File: rtl/sce_sync_edge.sv
module sce_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= line_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[g] <= 1'b0;
      else     chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign edge_o = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/sce_edge_count.sv
module sce_edge_count #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] cnt_q;

  always_comb begin
    if (cnt_q == TOP) cnt_nxt_o = cnt_q;
    else              cnt_nxt_o = cnt_q + W'(inc_i);
  end

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

  assert_sat_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == TOP && !clr_i) |=> (cnt_q == TOP));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/sce_bit_slice.sv
module sce_bit_slice #(
  parameter int W  = 6,
  parameter int LO = 20,
  parameter int HI = 60
) (
  input  logic [W-1:0] cnt_i,
  output logic         bit_o
);
  assign bit_o = (cnt_i > W'(LO)) && (cnt_i < W'(HI));
endmodule

// File: rtl/sce_interval.sv
module sce_interval #(
  parameter int BIT_TICKS = 100,
  parameter int IDX_W     = 6,
  localparam int PH_W     = $clog2(BIT_TICKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  output logic             end_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [PH_W-1:0]  phase_q;
  logic [IDX_W-1:0] idx_q;

  assign end_o = run_i && (phase_q == PH_W'(BIT_TICKS - 1));
  assign idx_o = idx_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      phase_q <= '0;
      idx_q   <= '0;
    end else if (end_o) begin
      phase_q <= '0;
      idx_q   <= idx_q + IDX_W'(1);
    end else begin
      phase_q <= phase_q + PH_W'(1);
    end
  end

  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
    phase_q < PH_W'(BIT_TICKS));
endmodule

// File: rtl/sce_demod.sv
module sce_demod import sce_pkg::*; #(
  parameter int TIMER_W     = 16,
  parameter int WAIT_TICKS  = 64,
  parameter int BIT_TICKS   = 100,
  parameter int EDGE_W      = 6,
  parameter int EDGE_LO     = 20,
  parameter int EDGE_HI     = 60,
  parameter int MAX_BITS    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(MAX_BITS + 1),
  localparam int REQ_W      = $clog2(MAX_BITS) + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                line_i,
  input  logic [REQ_W-1:0]    nbits_i,
  input  logic                decrypt_i,
  input  logic                ks_bit_i,
  output logic                ks_adv_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic [CNT_W-1:0]    nbits_o,
  output logic                valid_o,
  output logic                timer_clr_o
);
  localparam int SEL_W = $clog2(MAX_BITS);
  localparam int ADV_W = CNT_W + 2;

  sce_state_t          state_q;
  logic [TIMER_W-1:0]  timer_q;
  logic                adv_step_q;
  logic [CNT_W-1:0]    coll_idx_q;
  logic [CNT_W-1:0]    nbits_q;
  logic                dec_q;
  logic [MAX_BITS-1:0] word_q;
  logic [MAX_BITS-1:0] word_nxt;
  logic [MAX_BITS-1:0] data_q;
  logic [CNT_W-1:0]    cnt_out_q;
  logic                valid_q;
  logic                clr_q;

  logic                edge_w;
  logic                ivl_end;
  logic [CNT_W-1:0]    ivl_idx;
  logic [EDGE_W-1:0]   ecnt;
  logic [EDGE_W-1:0]   ecnt_nxt;
  logic                bit_dec;
  logic                cnt_clr;
  logic [CNT_W-1:0]    req_capped;
  logic                wait_done;
  logic                last_coll;
  logic                last_bit;

  sce_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_i(line_i), .edge_o(edge_w)
  );

  assign cnt_clr = (state_q != ST_RX) || ivl_end;

  sce_edge_count #(.W(EDGE_W)) u_ecnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .inc_i(edge_w),
    .cnt_o(ecnt), .cnt_nxt_o(ecnt_nxt)
  );

  sce_bit_slice #(.W(EDGE_W), .LO(EDGE_LO), .HI(EDGE_HI)) u_slice (
    .cnt_i(ecnt_nxt), .bit_o(bit_dec)
  );

  sce_interval #(.BIT_TICKS(BIT_TICKS), .IDX_W(CNT_W)) u_ivl (
    .clk(clk), .rst(rst), .run_i(state_q == ST_RX),
    .end_o(ivl_end), .idx_o(ivl_idx)
  );

  assign req_capped = (nbits_i > REQ_W'(MAX_BITS)) ? CNT_W'(MAX_BITS)
                                                   : nbits_i[CNT_W-1:0];
  assign wait_done  = timer_q >= TIMER_W'(WAIT_TICKS - 1);
  assign last_coll  = coll_idx_q == (nbits_q - CNT_W'(1));
  assign last_bit   = ivl_idx == (nbits_q - CNT_W'(1));
  assign ks_adv_o   = (state_q == ST_ADV) || (state_q == ST_COLL);

  always_comb begin
    word_nxt = word_q;
    word_nxt[ivl_idx[SEL_W-1:0]] = word_q[ivl_idx[SEL_W-1:0]] ^ bit_dec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      timer_q    <= '0;
      adv_step_q <= 1'b0;
      coll_idx_q <= '0;
      nbits_q    <= '0;
      dec_q      <= 1'b0;
      word_q     <= '0;
      data_q     <= '0;
      cnt_out_q  <= '0;
      valid_q    <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      clr_q   <= 1'b0;
      if (state_q != ST_IDLE && timer_q != {TIMER_W{1'b1}})
        timer_q <= timer_q + TIMER_W'(1);
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q    <= ST_ADV;
            timer_q    <= '0;
            adv_step_q <= 1'b0;
            coll_idx_q <= '0;
            nbits_q    <= req_capped;
            dec_q      <= decrypt_i;
            word_q     <= '0;
          end
        end
        ST_ADV: begin
          adv_step_q <= 1'b1;
          if (adv_step_q)
            state_q <= (dec_q && nbits_q != '0) ? ST_COLL : ST_WAIT;
        end
        ST_COLL: begin
          word_q[coll_idx_q[SEL_W-1:0]] <= ks_bit_i;
          coll_idx_q <= coll_idx_q + CNT_W'(1);
          if (last_coll) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wait_done) begin
            if (nbits_q == '0) begin
              data_q    <= word_q;
              cnt_out_q <= nbits_q;
              valid_q   <= 1'b1;
              clr_q     <= 1'b1;
              timer_q   <= '0;
              state_q   <= ST_IDLE;
            end else begin
              state_q <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (ivl_end) begin
            word_q <= word_nxt;
            if (last_bit) begin
              data_q    <= word_nxt;
              cnt_out_q <= nbits_q;
              valid_q   <= 1'b1;
              clr_q     <= 1'b1;
              timer_q   <= '0;
              state_q   <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o      = data_q;
  assign nbits_o     = cnt_out_q;
  assign valid_o     = valid_q;
  assign timer_clr_o = clr_q;

  // Keystream advance tally per frame, used only by the checks below.
  logic [ADV_W-1:0] adv_seen_q;
  always_ff @(posedge clk) begin
    if (rst)                                adv_seen_q <= '0;
    else if (state_q == ST_IDLE && start_i) adv_seen_q <= '0;
    else if (ks_adv_o)                      adv_seen_q <= adv_seen_q + ADV_W'(1);
  end

  function automatic logic [MAX_BITS-1:0] low_ones(input logic [CNT_W-1:0] n);
    logic [MAX_BITS-1:0] m;
    m = '0;
    for (int k = 0; k < MAX_BITS; k++)
      if (k < int'(n)) m[k] = 1'b1;
    return m;
  endfunction

  assert_ks_budget_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (adv_seen_q == ADV_W'(2) + (dec_q ? ADV_W'(nbits_q) : ADV_W'(0))));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  assert_clr_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
    timer_clr_o == valid_o);

  assert_count_cap_R1: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (nbits_o <= CNT_W'(MAX_BITS)));

  assert_upper_clear_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((data_o & ~low_ones(nbits_o)) == '0));
endmodule

// File: tb/sce_demod_tb_top.sv
`timescale 1ns/1ps
module sce_demod_tb_top;
  localparam int WAIT = 64;
  localparam int BITT = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        line_i = 1'b0;
  logic [6:0]  nbits_i = '0;
  logic        decrypt_i = 1'b0;
  logic        ks_bit_i;
  logic        ks_adv_o;
  logic [31:0] data_o;
  logic [5:0]  nbits_o;
  logic        valid_o;
  logic        timer_clr_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int ks_pos = 0;

  always #5 clk = ~clk;

  sce_demod dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .line_i(line_i),
    .nbits_i(nbits_i), .decrypt_i(decrypt_i), .ks_bit_i(ks_bit_i),
    .ks_adv_o(ks_adv_o), .data_o(data_o), .nbits_o(nbits_o),
    .valid_o(valid_o), .timer_clr_o(timer_clr_o)
  );

  function automatic logic ksf(input int p);
    return ((((p * 29) + (p >> 2) + 3) % 7) < 3);
  endfunction

  assign ks_bit_i = ksf(ks_pos);
  always @(posedge clk) if (!rst && ks_adv_o) ks_pos <= ks_pos + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One frame: bit i carries (base + i*step) % 99 edges.
  task automatic run_frame(input int req, input bit dec, input int base,
                           input int step, input bit poke, input string tag);
    int n, target, pos0, vcount, vtime;
    int kk[32];
    logic [31:0] expw;
    n = (req > 32) ? 32 : req;
    target = WAIT + n * BITT;
    expw = '0;
    for (int i = 0; i < 32; i++) kk[i] = (base + i * step) % 99;
    for (int i = 0; i < n; i++) begin
      int ks;
      logic b;
      ks = (kk[i] > 63) ? 63 : kk[i];
      b = (ks > 20) && (ks < 60);
      if (dec) b = b ^ ksf(ks_pos + 2 + i);
      expw[i] = b;
    end
    pos0 = ks_pos;
    @(negedge clk);
    start_i = 1'b1; nbits_i = 7'(req); decrypt_i = dec;
    @(posedge clk);
    vcount = 0; vtime = -1;
    for (int t = 0; t <= target + 3; t++) begin
      int u;
      @(negedge clk);
      start_i = (poke && t == WAIT / 2) ? 1'b1 : 1'b0;
      if (poke && t == WAIT / 2) decrypt_i = ~dec;
      if (valid_o) begin vcount++; vtime = t; end
      if (t == target) begin
        chk(data_o == expw, {tag, " R3 R5 data"}, data_o, expw);
        chk(nbits_o == 6'(n), {tag, " R1 count"}, nbits_o, n);
        chk(timer_clr_o == 1'b1, {tag, " R7 timer restart"}, timer_clr_o, 1);
      end
      u = t + 2 - WAIT;
      if (u >= 0 && u < n * BITT)
        if ((u % BITT) < kk[u / BITT]) line_i = ~line_i;
    end
    chk(vcount == 1 && vtime == target, {tag, " R7 R2 valid timing"}, vtime, target);
    chk((ks_pos - pos0) == 2 + (dec ? n : 0), {tag, " R6 keystream steps"},
        ks_pos - pos0, 2 + (dec ? n : 0));
    @(negedge clk);
    chk(data_o == expw && nbits_o == 6'(n), {tag, " R7 hold"}, data_o, expw);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(valid_o == 1'b0, "R7 reset valid", valid_o, 0);
    chk(data_o == 32'h0, "R5 reset data", data_o, 0);
    chk(ks_adv_o == 1'b0, "R6 reset advance", ks_adv_o, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R3 R4: every edge count 0..98 across four frames.
    for (int f = 0; f < 4; f++) run_frame(32, 1'b0, f * 32, 1, 1'b0, "sweep");
    // R6: decryption with various lengths.
    run_frame(1, 1'b1, 42, 1, 1'b0, "dec1");
    run_frame(5, 1'b1, 18, 13, 1'b0, "dec5");
    run_frame(17, 1'b1, 7, 11, 1'b0, "dec17");
    run_frame(31, 1'b1, 3, 17, 1'b0, "dec31");
    run_frame(32, 1'b1, 21, 19, 1'b0, "dec32");
    // R1: capped requests.
    run_frame(40, 1'b0, 20, 7, 1'b0, "cap40");
    run_frame(127, 1'b1, 59, 23, 1'b0, "cap127");
    // R9: empty frame.
    run_frame(0, 1'b1, 0, 1, 1'b0, "zero R9");
    // R8: start during a frame is ignored.
    run_frame(9, 1'b1, 30, 9, 1'b1, "poke R8");
    run_frame(12, 1'b0, 40, 5, 1'b1, "poke2 R8");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0x1 expected=0x0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule